// File: doc/BRIEF.md
# Timestamped Sample Cluster Writer

This block sits between the sampling front end of a logic capture engine and its capture memory. Once a start command arrives, it takes one 16-bit sample every `div_frac + 1` clock cycles. It collects the samples seven at a time into clusters. Each cluster is sent to memory as one wide write beat that carries a 16-bit timestamp and the seven samples.

The block tracks its write position as a line number and an event index. Each line holds 448 events (64 clusters of 7). Positions are reported as `line << 9 | event`. The block latches the position at which the trigger condition first held. After the trigger, it runs for a programmed number of further events and then stops.

Capture also ends on a stop command, or when the memory is about to fill. When capture ends, the stop position keeps the position of the last event written. Both positions can be read back one byte at a time, least significant byte first.

Top module: `cap_cluster_writer`

## Requirements
- R1: A start command (`start_cmd` high at a clock edge) sets `running` and clears the timestamp, the write position, `trig_fired`, `trig_pos` and `stop_pos` to zero. It takes effect from any state.
- R2: While running, one event is sampled from `smp_in` every `div_frac + 1` cycles. Event 0 is sampled at the (`div_frac + 1`)-th clock edge after the start edge, so `div_frac` = 0 to 255 gives a divider of 1 to 256.
- R3: A write beat carries `wr_data[15:0]` = the timestamp of the cluster's first event, and `wr_data[16*j+31:16*j+16]` = sample j of the cluster (j = 0 to 6). The timestamp counts events since start, modulo 2^16. Slots that were not filled read as zero.
- R4: A beat is issued (`wr_valid` for one cycle) in the cycle after the seventh event of a cluster, and after the final event of a capture. `wr_addr` = line × 64 + cluster index, so beats carry addresses 0, 1, 2, … in order.
- R5: Positions are `line << 9 | event`, with the event index running from 0 to 447 and then moving on to the next line. `stop_pos` is the position of the last event written.
- R6: `trig_in` is looked at only in cycles where an event is sampled. The first such event with `trig_in` high sets `trig_fired` and stores its position in `trig_pos`. Later trigger inputs change neither until the next start.
- R7: After the trigger event, exactly (`post_len` + 1) << `POST_SHIFT` further events are written, and then `running` falls.
- R8: `stop_cmd` while running ends the capture at that edge. An event due at the same edge is not written, and a partly filled cluster is flushed as one beat. `stop_cmd` while idle has no effect.
- R9: Capture stops by itself after event 447 of line 2^`LINE_W` − 2. This means the line field of the write position never reaches its all-ones value.
- R10: `rd_byte` presents, one cycle after `rd_idx`, byte `rd_idx` of `trig_pos` (indices 0 to 2, least significant byte first) or byte `rd_idx` − 3 of `stop_pos` (indices 3 to 5). Indices 6 and 7 read zero.
- R11: After reset, `running`, `wr_valid`, `trig_fired`, `trig_pos`, `stop_pos` and `rd_byte` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Begin a new capture |
| stop_cmd | input | 1 | End the running capture |
| div_frac | input | 8 | Sample divider minus one |
| post_len | input | 8 | Post-trigger length code |
| smp_in | input | 16 | Logic sample word |
| trig_in | input | 1 | Trigger condition from the matcher |
| rd_idx | input | 3 | Position byte select |
| wr_valid | output | 1 | Cluster write beat strobe |
| wr_addr | output | LINE_W+6 | Cluster address in capture memory |
| wr_data | output | 128 | Timestamp and seven samples |
| running | output | 1 | Capture in progress |
| trig_fired | output | 1 | Trigger has fired in this capture |
| trig_pos | output | 24 | Position of the trigger event |
| stop_pos | output | 24 | Position of the last written event |
| rd_byte | output | 8 | Selected position byte |

## Verification
The hardest condition to reach is the memory-full stop. It needs thousands of lines' worth of events, and it gets harder still when a trigger lands so close to the end that the post-trigger span would run past it. The bench builds the writer with a three-bit line field, so that full is reached after 3136 events at divider 1. It places one trigger a few events before that limit. Stops that fall mid-cluster and stops that collide with a sample tick are placed directly, and the rest come from seeded random dividers, trigger events and stop cycles.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
  localparam int EVT_PER_CL   = 7;
  localparam int CL_PER_LINE  = 64;
  localparam int EVT_PER_LINE = EVT_PER_CL * CL_PER_LINE;
  localparam int EVT_W        = 9;
  localparam int SLOT_W       = 3;
  localparam int CL_W         = 6;
  localparam int POS_W        = 24;

  typedef enum logic {ST_IDLE, ST_RUN} run_st_e;
endpackage

// File: rtl/cwr_rate_div.sv
module cwr_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [DIV_W-1:0] frac,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en || clr) cnt_q <= '0;
    else if (cnt_q >= frac) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && !clr && (cnt_q >= frac);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && frac != '0 && !clr) |=> (!tick || frac == '0));
endmodule

// File: rtl/cwr_pos_track.sv
module cwr_pos_track import cwr_pkg::*; #(
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot,
  output logic [CL_W-1:0]   cl,
  output logic [EVT_W-1:0]  evt,
  output logic [LINE_W-1:0] line
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(EVT_PER_CL - 1);
  localparam logic [CL_W-1:0]   CL_LAST   = CL_W'(CL_PER_LINE - 1);
  localparam logic [EVT_W-1:0]  EVT_LAST  = EVT_W'(EVT_PER_LINE - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      slot <= '0;
      cl   <= '0;
      evt  <= '0;
      line <= '0;
    end else if (adv) begin
      if (slot == SLOT_LAST) begin
        slot <= '0;
        if (cl == CL_LAST) begin
          cl   <= '0;
          line <= line + 1'b1;
        end else begin
          cl <= cl + 1'b1;
        end
      end else begin
        slot <= slot + 1'b1;
      end
      evt <= (evt == EVT_LAST) ? '0 : evt + 1'b1;
    end
  end

  // R5
  evt_range_chk: assert property (@(posedge clk) disable iff (rst)
    evt <= EVT_LAST && slot <= SLOT_LAST);
  // R5
  evt_split_chk: assert property (@(posedge clk) disable iff (rst)
    32'(evt) == 32'(cl) * EVT_PER_CL + 32'(slot));
endmodule

// File: rtl/cwr_cluster_pack.sv
module cwr_cluster_pack import cwr_pkg::*; #(
  parameter int SMP_W  = 16,
  parameter int TS_W   = 16,
  parameter int ADDR_W = 21,
  localparam int DATA_W = TS_W + SMP_W * EVT_PER_CL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic              close,
  input  logic              flush,
  input  logic [SLOT_W-1:0] slot,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [DATA_W-1:0] beat_data
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(EVT_PER_CL - 1);

  logic [SMP_W-1:0] buf_q [EVT_PER_CL];
  logic [SMP_W-1:0] buf_n [EVT_PER_CL];
  logic [TS_W-1:0]  ts_q, ts_n;
  logic [DATA_W-1:0] pack_n;
  logic emit;

  always_comb begin
    for (int j = 0; j < EVT_PER_CL; j++) buf_n[j] = buf_q[j];
    ts_n = ts_q;
    if (push) begin
      if (slot == '0) begin
        for (int j = 0; j < EVT_PER_CL; j++) buf_n[j] = '0;
        ts_n = ts_i;
      end
      buf_n[slot] = smp_i;
    end
  end

  assign pack_n[TS_W-1:0] = ts_n;
  for (genvar g = 0; g < EVT_PER_CL; g++) begin : g_slot
    assign pack_n[TS_W + g*SMP_W +: SMP_W] = buf_n[g];
  end

  assign emit = (push && (slot == SLOT_LAST || close)) || (flush && slot != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int j = 0; j < EVT_PER_CL; j++) buf_q[j] <= '0;
      ts_q       <= '0;
      beat_valid <= 1'b0;
      beat_addr  <= '0;
      beat_data  <= '0;
    end else begin
      for (int j = 0; j < EVT_PER_CL; j++) buf_q[j] <= buf_n[j];
      ts_q       <= ts_n;
      beat_valid <= emit;
      if (emit) begin
        beat_addr <= addr_i;
        beat_data <= pack_n;
      end
    end
  end

  // R4
  beat_src_chk: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> $past(push || flush));
  // R8
  push_flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && flush));
endmodule

// File: rtl/cap_cluster_writer.sv
module cap_cluster_writer import cwr_pkg::*; #(
  parameter int LINE_W     = 15,
  parameter int DIV_W      = 8,
  parameter int POST_W     = 8,
  parameter int POST_SHIFT = 8,
  parameter int SMP_W      = 16,
  parameter int TS_W       = 16,
  localparam int ADDR_W    = LINE_W + CL_W,
  localparam int DATA_W    = TS_W + SMP_W * EVT_PER_CL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic [DIV_W-1:0]  div_frac,
  input  logic [POST_W-1:0] post_len,
  input  logic [SMP_W-1:0]  smp_in,
  input  logic              trig_in,
  input  logic [2:0]        rd_idx,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              running,
  output logic              trig_fired,
  output logic [POS_W-1:0]  trig_pos,
  output logic [POS_W-1:0]  stop_pos,
  output logic [7:0]        rd_byte
);
  localparam int PCNT_W = POST_W + POST_SHIFT + 1;
  localparam logic [LINE_W-1:0] FULL_LINE = {LINE_W{1'b1}};
  localparam logic [LINE_W-1:0] LAST_LINE = FULL_LINE - 1'b1;
  localparam logic [EVT_W-1:0]  EVT_LAST  = EVT_W'(EVT_PER_LINE - 1);

  run_st_e st_q;
  logic tick_raw, tick, stop_ev, last_evt;
  logic [SLOT_W-1:0] slot;
  logic [CL_W-1:0]   cl;
  logic [EVT_W-1:0]  evt;
  logic [LINE_W-1:0] line;
  logic [POS_W-1:0]  cur_pos;
  logic [TS_W-1:0]   ts_q;
  logic [PCNT_W-1:0] post_cnt_q, post_k;
  logic [2*POS_W-1:0] rd_cat;

  assign running = (st_q == ST_RUN);
  assign tick    = running && tick_raw && !start_cmd && !stop_cmd;
  assign stop_ev = running && stop_cmd && !start_cmd;
  assign post_k  = (PCNT_W'(post_len) + PCNT_W'(1)) << POST_SHIFT;

  always_comb begin
    cur_pos = '0;
    cur_pos[EVT_W-1:0] = evt;
    cur_pos[EVT_W +: LINE_W] = line;
  end

  assign last_evt = tick && ((trig_fired && post_cnt_q == PCNT_W'(1)) ||
                             (evt == EVT_LAST && line == LAST_LINE));

  cwr_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(running), .clr(start_cmd),
    .frac(div_frac), .tick(tick_raw)
  );

  cwr_pos_track #(.LINE_W(LINE_W)) u_pos (
    .clk(clk), .rst(rst), .clr(start_cmd), .adv(tick),
    .slot(slot), .cl(cl), .evt(evt), .line(line)
  );

  cwr_cluster_pack #(.SMP_W(SMP_W), .TS_W(TS_W), .ADDR_W(ADDR_W)) u_pack (
    .clk(clk), .rst(rst), .clr(start_cmd), .push(tick), .close(last_evt),
    .flush(stop_ev), .slot(slot), .addr_i({line, cl}), .smp_i(smp_in),
    .ts_i(ts_q), .beat_valid(wr_valid), .beat_addr(wr_addr), .beat_data(wr_data)
  );

  assign rd_cat = {stop_pos, trig_pos};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      trig_fired <= 1'b0;
      trig_pos   <= '0;
      stop_pos   <= '0;
      post_cnt_q <= '0;
      ts_q       <= '0;
      rd_byte    <= '0;
    end else begin
      rd_byte <= (rd_idx < 3'd6) ? rd_cat[rd_idx*8 +: 8] : 8'h00;
      if (start_cmd) begin
        st_q       <= ST_RUN;
        trig_fired <= 1'b0;
        trig_pos   <= '0;
        stop_pos   <= '0;
        post_cnt_q <= '0;
        ts_q       <= '0;
      end else if (stop_ev) begin
        st_q <= ST_IDLE;
      end else if (tick) begin
        ts_q     <= ts_q + 1'b1;
        stop_pos <= cur_pos;
        if (trig_fired) begin
          post_cnt_q <= post_cnt_q - 1'b1;
        end else if (trig_in) begin
          trig_fired <= 1'b1;
          trig_pos   <= cur_pos;
          post_cnt_q <= post_k;
        end
        if (last_evt) st_q <= ST_IDLE;
      end
    end
  end

  // R9
  no_full_line_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> line != FULL_LINE);
  // R6
  trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_fired && !start_cmd) |=> (trig_fired && $stable(trig_pos)));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !start_cmd) |=> !running);
  // R7
  post_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && trig_fired && !tick && !start_cmd) |=> $stable(post_cnt_q));
endmodule

// File: tb/cap_cluster_writer_bench.sv
module cap_cluster_writer_bench;
  timeunit 1ns; timeprecision 1ps;

  localparam int LW = 3;
  localparam int PS = 2;
  localparam int FULL_EV = ((1 << LW) - 1) * 448;

  logic clk = 1'b0, rst = 1'b1, start_cmd = 1'b0, stop_cmd = 1'b0, trig_in = 1'b0;
  logic [7:0] div_frac = '0, post_len = '0;
  logic [15:0] smp_in = '0;
  logic [2:0] rd_idx = '0;
  logic wr_valid, running, trig_fired;
  logic [LW+5:0] wr_addr;
  logic [127:0] wr_data;
  logic [23:0] trig_pos, stop_pos;
  logic [7:0] rd_byte;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] smp_log [0:4095];

  always #2.5 clk = ~clk;

  cap_cluster_writer #(.LINE_W(LW), .POST_SHIFT(PS)) u_cap_cluster_writer (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .div_frac(div_frac), .post_len(post_len), .smp_in(smp_in), .trig_in(trig_in),
    .rd_idx(rd_idx), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .running(running), .trig_fired(trig_fired), .trig_pos(trig_pos),
    .stop_pos(stop_pos), .rd_byte(rd_byte)
  );

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pos_of(int n);
    return ((n / 448) << 9) | (n % 448);
  endfunction

  function automatic logic [127:0] beat_of(int g, int nev);
    logic [127:0] v;
    v = '0;
    v[15:0] = 16'(7 * g);
    for (int j = 0; j < 7; j++)
      if (7 * g + j < nev) v[16*(j+1) +: 16] = smp_log[7*g+j];
    return v;
  endfunction

  task automatic run(int frac, int post, int t, int stop_cyc);
    int d, k, cap, nev, beats, tp;
    bit fired;
    string req;
    logic [47:0] cat;
    d = frac + 1;
    k = (post + 1) << PS;
    cap = FULL_EV;
    req = "R9";
    if (stop_cyc > 0 && (stop_cyc - 1) / d < cap) begin
      cap = (stop_cyc - 1) / d;
      req = "R8";
    end
    fired = (t >= 0 && t < cap);
    nev = cap;
    if (fired && t + 1 + k < cap) begin
      nev = t + 1 + k;
      req = "R7";
    end
    @(negedge clk);
    div_frac = 8'(frac); post_len = 8'(post); start_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0;
    beats = 0;
    for (int c = 1; c < 20000; c++) begin
      if (c == 1) begin
        chk("R1", "running", running, 1);
        chk("R1", "trig_fired", trig_fired, 0);
        chk("R1", "stop_pos", stop_pos, 0);
        chk("R1", "trig_pos", trig_pos, 0);
      end
      if (wr_valid) begin
        chk("R4", "beat addr", wr_addr, beats);
        chk("R2 R3", "beat data", wr_data, beat_of(beats, nev));
        beats++;
      end
      if (c > 1 && !running) break;
      smp_in = 16'($urandom);
      stop_cmd = (c == stop_cyc);
      if (c % d == 0) begin
        int n;
        n = c / d - 1;
        if (c != stop_cyc && n < 4096) smp_log[n] = smp_in;
        trig_in = (t < 0 || n < t) ? 1'b0 : (n == t) ? 1'b1 : 1'($urandom);
      end else begin
        trig_in = 1'($urandom);
      end
      @(negedge clk);
    end
    stop_cmd = 1'b0; trig_in = 1'b0;
    chk(req, "running at end", running, 0);
    chk(req == "R9" ? "R9" : "R5", "stop_pos", stop_pos, pos_of(nev - 1));
    chk("R4", "beat count", beats, (nev + 6) / 7);
    chk("R6", "trig_fired", trig_fired, fired);
    tp = fired ? pos_of(t) : 0;
    chk("R6", "trig_pos", trig_pos, tp);
    cat = {24'(pos_of(nev - 1)), 24'(tp)};
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      @(negedge clk);
      chk("R10", "rd_byte", rd_byte, (i < 6) ? cat[i*8 +: 8] : 8'h00);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "running", running, 0);
    chk("R11", "wr_valid", wr_valid, 0);
    chk("R11", "trig_fired", trig_fired, 0);
    chk("R11", "stop_pos", stop_pos, 0);
    chk("R11", "trig_pos", trig_pos, 0);
    chk("R11", "rd_byte", rd_byte, 0);
    stop_cmd = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
    chk("R8", "idle stop ignored", running, 0);
    run(0, 1, 20, 0);
    run(4, 0, -1, 203);
    run(0, 0, -1, 0);
    run(255, 0, 2, 0);
    run(0, 15, 5, 30);
    run(0, 3, 3120, 0);
    run(2, 0, -1, 31);
    for (int r = 0; r < 6; r++) begin
      int f, p, t, s;
      f = int'($urandom % 8);
      p = int'($urandom % 16);
      t = ($urandom % 4 == 0) ? -1 : int'($urandom % 200);
      s = ($urandom % 2 == 0) ? 0 : 20 + int'($urandom % 800);
      run(f, p, t, s);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule